// File: doc/BRIEF.md
# Transmit Symbol Framer with Clock-Compensation Skip Scheduling

This block sits on the transmit side of an 8b/10b-style serial lane. It takes packet bytes from the layers above and turns them into a stream of 9-bit symbols. Each symbol is an 8-bit value plus a control flag, and the stream goes to an external 8b/10b encoder. Each packet is wrapped in a control symbol that opens it and a control symbol that closes it. The opening symbol depends on whether the packet is a transaction packet or a link packet. The closing symbol depends on whether the sender has nullified the packet. When the lane has nothing to carry, the block sends a plain filler byte.

For clock compensation, the block counts every symbol the encoder accepts. Once the count reaches a programmable threshold, a four-symbol skip set is due. It is sent at the next packet boundary, ahead of any waiting packet, and a packet is never split to make room for it. If a packet is still open when the count reaches the late limit, a sticky error flag is raised.

The sequencer has four states. In `ST_IDLE` it emits a skip comma, an opening symbol or filler. In `ST_PAYLOAD` it passes packet bytes through. `ST_CLOSE` emits the closing symbol and `ST_SKIP` emits the skip fillers of a skip set. The transitions are:

- `ST_IDLE`→`ST_SKIP`: the comma is accepted while a skip set is due.
- `ST_IDLE`→`ST_PAYLOAD`: an opening symbol is accepted.
- `ST_PAYLOAD`→`ST_CLOSE`: the last byte is accepted.
- `ST_CLOSE`→`ST_IDLE`: the closing symbol is accepted.
- `ST_SKIP`→`ST_IDLE`: the final skip filler is accepted.

In every state, a cycle in which no symbol is accepted leaves the state unchanged.

Top module: `sym_framer`

## Requirements
- R1: A transaction packet (`pkt_link`=0 with the first byte) opens with the control symbol 0xFB (K flag 1). This is the symbol sent in `ST_IDLE` when a packet is waiting and no skip set is due.
- R2: A link packet (`pkt_link`=1) opens with the control symbol 0x5C (K flag 1).
- R3: After the opening symbol, the packet bytes follow in order with the K flag 0. A byte is consumed (`pkt_valid` and `pkt_ready`) exactly when its symbol is accepted. `sym_valid` is 0 while the source stalls in the middle of a packet.
- R4: A packet whose last byte comes with `pkt_nullify`=0 closes with the control symbol 0xFD (K flag 1).
- R5: A packet whose last byte comes with `pkt_nullify`=1 closes with the control symbol 0xF7 (K flag 1). `pkt_nullify` on any other byte has no effect.
- R6: A skip set is the comma 0xBC (K flag 1) followed by exactly three 0x1C symbols (K flag 1), with nothing between them.
- R7: The interval count is 0 on the cycle the comma is accepted and rises by one for each other accepted symbol. It saturates at its maximum. A skip set is due while the count is at least max(`cfg_skip_thr`, 1180). A due skip set starts only in `ST_IDLE`, and it goes ahead of a waiting packet.
- R8: When neither a packet nor a skip set is being sent, the output is 0x00 with the K flag 0 and `sym_valid`=1.
- R9: While `sym_ready` is 0, no input byte is consumed, the interval count does not change, and the symbol shown in `ST_CLOSE` or `ST_SKIP` stays the same.
- R10: `skip_late` rises one cycle after the interval count is at least 1538 while a packet is open (`ST_PAYLOAD` or `ST_CLOSE`). It then stays 1 until reset.
- R11: During and right after reset, the block is in `ST_IDLE` with count 0 and `skip_late`=0. It shows filler (0x00, K flag 0, `sym_valid`=1) and `pkt_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_skip_thr | input | CNT_W | Skip interval threshold; values below 1180 act as 1180 |
| pkt_valid | input | 1 | Packet byte present |
| pkt_ready | output | 1 | Packet byte taken this cycle |
| pkt_byte | input | 8 | Packet byte |
| pkt_last | input | 1 | Byte is the last of its packet |
| pkt_link | input | 1 | 1 = link packet, 0 = transaction packet (read with the first byte) |
| pkt_nullify | input | 1 | Nullify the packet (read with the last byte) |
| sym_valid | output | 1 | Output symbol present |
| sym_ready | input | 1 | Encoder accepts the symbol |
| sym_value | output | 8 | Symbol value |
| sym_is_k | output | 1 | Symbol is a control symbol |
| skip_late | output | 1 | Sticky: skip interval overran during a packet |

## Verification
The symbol, its flag, `sym_valid` and `pkt_ready` are combinational from the registered state and the current inputs, so each is due in the same cycle as the inputs that select it. A state change is due at the next rising edge. `skip_late` is due one edge after its condition is met. The bench drives inputs on the falling edge and compares one time unit later against a reference model that keeps a queue of expected symbols. The model updates its own count, queue and late flag only after the rising edge, so every comparison sees state one edge old. Random ready gaps and source bubbles move the skip sets around the packet boundaries, and a packet longer than the late limit drives the error flag.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PAYLOAD = 2'd1,
        ST_CLOSE   = 2'd2,
        ST_SKIP    = 2'd3
    } frm_state_e;

    typedef struct packed {
        logic       k;
        logic [7:0] val;
    } sym_t;

    localparam sym_t SYM_FILL       = '{k: 1'b0, val: 8'h00};
    localparam sym_t SYM_TXN_OPEN   = '{k: 1'b1, val: 8'hFB};
    localparam sym_t SYM_LINK_OPEN  = '{k: 1'b1, val: 8'h5C};
    localparam sym_t SYM_GOOD_CLOSE = '{k: 1'b1, val: 8'hFD};
    localparam sym_t SYM_BAD_CLOSE  = '{k: 1'b1, val: 8'hF7};
    localparam sym_t SYM_COMMA      = '{k: 1'b1, val: 8'hBC};
    localparam sym_t SYM_SKIP       = '{k: 1'b1, val: 8'h1C};

endpackage

// File: rtl/sfr_code_sel.sv
module sfr_code_sel
    import sfr_pkg::*;
(
    input  logic is_link,
    input  logic is_bad,
    output sym_t open_sym,
    output sym_t close_sym
);

    // opening symbol follows packet class, closing symbol follows nullify
    assign open_sym  = is_link ? SYM_LINK_OPEN : SYM_TXN_OPEN;
    assign close_sym = is_bad  ? SYM_BAD_CLOSE : SYM_GOOD_CLOSE;

endmodule

// File: rtl/sfr_skip_sched.sv
module sfr_skip_sched #(
    parameter int CNT_W    = 11,
    parameter int MIN_GAP  = 1180,
    parameter int LATE_GAP = 1538
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_thr,
    input  logic             advance,
    input  logic             restart,
    input  logic             in_packet,
    output logic             pending,
    output logic             late,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] MIN_L   = CNT_W'(MIN_GAP);
    localparam logic [CNT_W-1:0] LATE_L  = CNT_W'(LATE_GAP);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_thr;
    logic             late_q;

    assign eff_thr = (cfg_thr < MIN_L) ? MIN_L : cfg_thr;
    assign pending = (cnt_q >= eff_thr);
    assign late    = late_q;
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            late_q <= 1'b0;
        end else begin
            if (restart) begin
                cnt_q <= '0;
            end else if (advance && (cnt_q != CNT_TOP)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            late_q <= late_q | (in_packet && (cnt_q >= LATE_L));
        end
    end

endmodule

// File: rtl/sym_framer.sv
module sym_framer
    import sfr_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int MIN_GAP    = 1180,
    parameter int LATE_GAP   = 1538,
    parameter int SKP_REPEAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_skip_thr,
    input  logic             pkt_valid,
    output logic             pkt_ready,
    input  logic [7:0]       pkt_byte,
    input  logic             pkt_last,
    input  logic             pkt_link,
    input  logic             pkt_nullify,
    output logic             sym_valid,
    input  logic             sym_ready,
    output logic [7:0]       sym_value,
    output logic             sym_is_k,
    output logic             skip_late
);

    localparam int               IDX_W    = $clog2(SKP_REPEAT + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SKP_REPEAT - 1);

    frm_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             null_q, null_d;
    logic             fire;
    logic             skip_due;
    logic             skip_restart;
    logic             in_packet;
    logic [CNT_W-1:0] skip_count;
    sym_t             cur_sym;
    sym_t             open_sym;
    sym_t             close_sym;

    sfr_code_sel u_code_sel (
        .is_link   (pkt_link),
        .is_bad    (null_q),
        .open_sym  (open_sym),
        .close_sym (close_sym)
    );

    sfr_skip_sched #(
        .CNT_W    (CNT_W),
        .MIN_GAP  (MIN_GAP),
        .LATE_GAP (LATE_GAP)
    ) u_skip_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_thr   (cfg_skip_thr),
        .advance   (fire),
        .restart   (skip_restart),
        .in_packet (in_packet),
        .pending   (skip_due),
        .late      (skip_late),
        .count     (skip_count)
    );

    assign fire         = sym_valid & sym_ready;
    assign skip_restart = fire && (state_q == ST_IDLE) && skip_due;
    assign in_packet    = (state_q == ST_PAYLOAD) || (state_q == ST_CLOSE);
    assign sym_value    = cur_sym.val;
    assign sym_is_k     = cur_sym.k;

    // output decode
    always_comb begin
        sym_valid = 1'b1;
        pkt_ready = 1'b0;
        cur_sym   = SYM_FILL;
        unique case (state_q)
            ST_IDLE: begin
                if (skip_due) begin
                    cur_sym = SYM_COMMA;
                end else if (pkt_valid) begin
                    cur_sym = open_sym;
                end
            end
            ST_PAYLOAD: begin
                sym_valid = pkt_valid;
                pkt_ready = sym_ready;
                cur_sym   = '{k: 1'b0, val: pkt_byte};
            end
            ST_CLOSE: cur_sym = close_sym;
            ST_SKIP:  cur_sym = SYM_SKIP;
            default:  cur_sym = SYM_FILL;
        endcase
    end

    // transitions
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        null_d  = null_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fire) begin
                    if (skip_due) begin
                        state_d = ST_SKIP;
                        idx_d   = '0;
                    end else if (pkt_valid) begin
                        state_d = ST_PAYLOAD;
                    end
                end
            end
            ST_PAYLOAD: begin
                if (fire && pkt_last) begin
                    state_d = ST_CLOSE;
                    null_d  = pkt_nullify;
                end
            end
            ST_CLOSE: begin
                if (fire) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SKIP: begin
                if (fire) begin
                    if (idx_q == IDX_LAST) begin
                        state_d = ST_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            null_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            null_q  <= null_d;
        end
    end

endmodule

// File: rtl/sym_framer_chk.sv
module sym_framer_chk
    import sfr_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int MIN_GAP = 1180
) (
    input logic             clk,
    input logic             rst_n,
    input frm_state_e       state_q,
    input logic [CNT_W-1:0] skip_count,
    input logic             pkt_valid,
    input logic             pkt_ready,
    input logic [7:0]       pkt_byte,
    input logic             sym_valid,
    input logic             sym_ready,
    input logic [7:0]       sym_value,
    input logic             sym_is_k,
    input logic             skip_late
);

    localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_GAP);

    // R3
    byte_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |-> (sym_valid && sym_ready && !sym_is_k && (sym_value == pkt_byte)));

    // R6
    skp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready && sym_is_k && (sym_value == 8'hBC)) |=> (sym_is_k && (sym_value == 8'h1C)));

    // R7
    comma_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_is_k && (sym_value == 8'hBC)) |-> ((state_q == ST_IDLE) && (skip_count >= MIN_L)));

    // R8
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !pkt_valid && (skip_count < MIN_L)) |-> (sym_valid && !sym_is_k && (sym_value == 8'h00)));

    // R9
    hold_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == ST_SKIP) || (state_q == ST_CLOSE)) && !sym_ready) |=> ($stable(sym_value) && $stable(sym_is_k)));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sym_valid && sym_ready) |=> $stable(skip_count));

    // R10
    late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_late |=> skip_late);

endmodule

bind sym_framer sym_framer_chk #(
    .CNT_W   (CNT_W),
    .MIN_GAP (MIN_GAP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .skip_count (skip_count),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_byte   (pkt_byte),
    .sym_valid  (sym_valid),
    .sym_ready  (sym_ready),
    .sym_value  (sym_value),
    .sym_is_k   (sym_is_k),
    .skip_late  (skip_late)
);

// File: tb/sym_framer_bench.sv
module sym_framer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 11;
    localparam int WDOG       = 100000;

    logic             clk;
    logic             rst_n;
    logic [CNT_W-1:0] cfg_skip_thr;
    logic             pkt_valid;
    logic             pkt_ready;
    logic [7:0]       pkt_byte;
    logic             pkt_last;
    logic             pkt_link;
    logic             pkt_nullify;
    logic             sym_valid;
    logic             sym_ready;
    logic [7:0]       sym_value;
    logic             sym_is_k;
    logic             skip_late;

    sym_framer u_sym_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_skip_thr (cfg_skip_thr),
        .pkt_valid    (pkt_valid),
        .pkt_ready    (pkt_ready),
        .pkt_byte     (pkt_byte),
        .pkt_last     (pkt_last),
        .pkt_link     (pkt_link),
        .pkt_nullify  (pkt_nullify),
        .sym_valid    (sym_valid),
        .sym_ready    (sym_ready),
        .sym_value    (sym_value),
        .sym_is_k     (sym_is_k),
        .skip_late    (skip_late)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int vectors = 0;
    int misses  = 0;

    // source packet bytes, one entry per byte
    byte unsigned q_byte[$];
    bit           q_last[$];
    bit           q_link[$];
    bit           q_null[$];

    // reference model
    int           m_cnt  = 0;
    bit           m_late = 0;
    bit           m_pkt  = 0;
    int           e_val[$];
    bit           e_k[$];
    bit           e_data[$];
    string        e_tag[$];

    int rdy_pct = 100;
    int bub_pct = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic add_pkt(input int len, input bit link, input bit nul);
        for (int i = 0; i < len; i++) begin
            q_byte.push_back(8'($urandom));
            q_last.push_back(i == len - 1);
            q_link.push_back(link);
            q_null.push_back(nul);
        end
    endtask

    task automatic push_exp(input int v, input bit k, input bit d, input string t);
        e_val.push_back(v);
        e_k.push_back(k);
        e_data.push_back(d);
        e_tag.push_back(t);
    endtask

    function automatic int eff_thr();
        return (int'(cfg_skip_thr) < 1180) ? 1180 : int'(cfg_skip_thr);
    endfunction

    task automatic model_reset();
        m_cnt  = 0;
        m_late = 0;
        m_pkt  = 0;
        e_val.delete();
        e_k.delete();
        e_data.delete();
        e_tag.delete();
    endtask

    task automatic step();
        int    x_val;
        bit    x_k;
        bit    x_valid;
        bit    x_ready;
        string x_tag;
        int    decided;  // 0 queue head, 1 filler, 2 comma, 3 opening
        bit    fire;
        bit    in_pkt;
        @(negedge clk);
        sym_ready = ($urandom_range(99) < rdy_pct);
        if (q_byte.size() > 0 && !($urandom_range(99) < bub_pct)) begin
            pkt_valid   = 1'b1;
            pkt_byte    = q_byte[0];
            pkt_last    = q_last[0];
            pkt_link    = q_link[0];
            pkt_nullify = q_last[0] ? q_null[0] : 1'($urandom);
        end else begin
            pkt_valid   = 1'b0;
            pkt_byte    = 8'($urandom);
            pkt_last    = 1'($urandom);
            pkt_link    = 1'($urandom);
            pkt_nullify = 1'($urandom);
        end
        #1;
        if (e_val.size() > 0) begin
            decided = 0;
            x_val   = e_val[0];
            x_k     = e_k[0];
            x_tag   = e_tag[0];
            x_valid = e_data[0] ? pkt_valid : 1'b1;
        end else begin
            x_valid = 1'b1;
            if (m_cnt >= eff_thr()) begin
                decided = 2; x_val = 8'hBC; x_k = 1'b1; x_tag = "R7";
            end else if (pkt_valid) begin
                decided = 3; x_k = 1'b1;
                x_val = pkt_link ? 8'h5C : 8'hFB;
                x_tag = pkt_link ? "R2" : "R1";
            end else begin
                decided = 1; x_val = 8'h00; x_k = 1'b0; x_tag = "R8";
            end
        end
        x_ready = (e_val.size() > 0) && e_data[0] && sym_ready;
        check(sym_valid == x_valid, (decided == 0 && e_data[0]) ? "R3" : x_tag,
              "sym_valid", sym_valid, x_valid);
        if (x_valid) begin
            check(sym_value == x_val[7:0], x_tag, "sym_value", sym_value, x_val);
            check(sym_is_k == x_k, x_tag, "sym_is_k", sym_is_k, x_k);
        end
        check(pkt_ready == x_ready, sym_ready ? "R3" : "R9", "pkt_ready", pkt_ready, x_ready);
        check(skip_late == m_late, "R10", "skip_late", skip_late, m_late);
        fire   = x_valid && sym_ready;
        in_pkt = m_pkt && (e_val.size() > 0);
        @(posedge clk);
        if (in_pkt && m_cnt >= 1538) m_late = 1;
        if (fire) begin
            if (decided == 2) m_cnt = 0;
            else if (m_cnt < 2047) m_cnt = m_cnt + 1;
            if (decided == 0) begin
                if (e_data[0]) begin
                    void'(q_byte.pop_front());
                    void'(q_last.pop_front());
                    void'(q_link.pop_front());
                    void'(q_null.pop_front());
                end
                void'(e_val.pop_front());
                void'(e_k.pop_front());
                void'(e_data.pop_front());
                void'(e_tag.pop_front());
            end else if (decided == 2) begin
                m_pkt = 0;
                for (int i = 0; i < 3; i++) push_exp(8'h1C, 1'b1, 1'b0, "R6");
            end else if (decided == 3) begin
                m_pkt = 1;
                for (int i = 0; i < q_byte.size(); i++) begin
                    push_exp(q_byte[i], 1'b0, 1'b1, "R3");
                    if (q_last[i]) begin
                        if (q_null[i]) push_exp(8'hF7, 1'b1, 1'b0, "R5");
                        else           push_exp(8'hFD, 1'b1, 1'b0, "R4");
                        break;
                    end
                end
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        sym_ready = 1'b1;
        pkt_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(sym_valid == 1'b1, "R11", "reset sym_valid", sym_valid, 1);
        check(sym_value == 8'h00 && !sym_is_k, "R11", "reset symbol", {sym_is_k, sym_value}, 0);
        check(pkt_ready == 1'b0, "R11", "reset pkt_ready", pkt_ready, 0);
        check(skip_late == 1'b0, "R11", "reset skip_late", skip_late, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n        = 1'b0;
        cfg_skip_thr = CNT_W'(1200);
        sym_ready    = 1'b1;
        pkt_valid    = 1'b0;
        pkt_byte     = '0;
        pkt_last     = 1'b0;
        pkt_link     = 1'b0;
        pkt_nullify  = 1'b0;
        do_reset();

        // mixed traffic: R1 R2 R3 R4 R5 R6 R7 R9 with ready gaps and bubbles
        rdy_pct = 80;
        bub_pct = 10;
        for (int c = 0; c < 6000; c++) begin
            if (q_byte.size() < 3)
                add_pkt($urandom_range(20, 1), 1'($urandom), ($urandom_range(3) == 0));
            step();
        end
        while (q_byte.size() > 0 || e_val.size() > 0) step();

        // idle lane, threshold below minimum is clamped: R7 R8
        cfg_skip_thr = '0;
        rdy_pct = 70;
        bub_pct = 0;
        for (int c = 0; c < 3000; c++) step();

        // long ready-low stretch: R9
        rdy_pct = 0;
        add_pkt(5, 1'b0, 1'b1);
        for (int c = 0; c < 40; c++) step();
        rdy_pct = 100;
        while (q_byte.size() > 0 || e_val.size() > 0) step();

        // overrun during a long packet: R10
        cfg_skip_thr = CNT_W'(2000);
        add_pkt(1700, 1'b1, 1'b0);
        while (q_byte.size() > 0 || e_val.size() > 0) step();
        for (int c = 0; c < 10; c++) step();
        check(skip_late == 1'b1, "R10", "late after overrun", skip_late, 1);

        // reset clears the sticky flag: R11
        do_reset();
        cfg_skip_thr = CNT_W'(1180);
        for (int c = 0; c < 1300; c++) begin
            if (q_byte.size() < 2)
                add_pkt($urandom_range(8, 1), 1'($urandom), 1'($urandom));
            step();
        end
        finish_run();
    end

endmodule